// File: doc/BRIEF.md
# Page-Wide Hamming ECC Engine

This block sits beside a NAND flash data bus and builds one single-error-correcting, double-error-detecting Hamming code over a whole page. Every data strobe adds the word on the bus to two 16-bit accumulators. Each set data bit has a position: its word index within the page, followed by its bit index within the word. The first accumulator XORs that position in. The second XORs in the bitwise inverse of the position. After a page is written, the two accumulators are the four code bytes that software stores in the spare area.

On a read, the stored code bytes are strobed in right after the page data. The engine forms a syndrome from the computed and the received code and classifies it:
- no error;
- a single data error, with its word and bit position;
- a single flipped bit in the code itself;
- an uncorrectable multiple error.

An erased page (all ones, code all ones) reads as a multiple error with an all-ones position. Software treats that as clean. Correcting the data buffer is left to software.

The controller is a four-state machine.
- ST_DATA: accumulate data words.
- ST_CODE: capture the received code units.
- ST_CHECK: classify the syndrome for one cycle.
- ST_DONE: hold the result.

Its transitions are:
- ST_DATA to ST_CODE on the strobe that carries the last data word.
- ST_CODE to ST_CHECK on the strobe that carries the last code unit.
- ST_CHECK to ST_DONE unconditionally.
- ST_DONE stays in ST_DONE.
- From any state back to ST_DATA on the clear strobe or on reset.

Top module: `ecc_page_engine`

## Requirements
- R1: After reset or a clear strobe, `par_o`, `npar_o`, `err_any`, `err_multi`, `err_code` and `done` are 0 and `code_rdy` is 0. The engine waits for the first data word in ST_DATA.
- R2: On each strobe in ST_DATA, the data word at index w is folded into the accumulators. For every set bit b, `par_o` is XORed with the 16-bit position {w[11:0], b[3:0]}, and `npar_o` is XORed with the inverse of that position. With `wide`=0 only `din[7:0]` counts and `din[15:8]` has no effect. Cycles without a strobe leave both accumulators unchanged.
- R3: The data length is (512 << `mode`) bytes: `mode` 0, 1, 2 and 3 give 512, 1024, 2048 and 4096 bytes. That is this many strobes with `wide`=0, and half as many with `wide`=1. `code_rdy` rises after the clock edge that samples the last data strobe, and not before.
- R4: While `code_rdy` is 1, `par_o` and `npar_o` hold the code to store. Code byte 0 is `par_o[7:0]`, byte 1 is `par_o[15:8]`, byte 2 is `npar_o[7:0]` and byte 3 is `npar_o[15:8]`. On a read, the code is strobed in as 4 bytes on `din[7:0]` (`wide`=0), or as 2 words with the lower byte holding the earlier code byte (`wide`=1).
- R5: `done` is 0 one cycle after the edge that samples the last code strobe, and 1 one cycle later. While `done` is 1, further strobes change no output.
- R6: A code that matches the data gives `err_any`=0, `err_multi`=0, `err_code`=0 and `par_o`=0 at `done`.
- R7: A single flipped data bit gives `err_any`=1, `err_multi`=0 and `err_code`=0. `par_o` then equals {word index, bit index}.
- R8: A single flipped bit in the received code gives `err_any`=1, `err_code`=1 and `err_multi`=0.
- R9: Two flipped data bits give `err_any`=1, `err_multi`=1 and `err_code`=0.
- R10: An erased page (all data bits 1 and code bytes all 0xFF) gives `err_multi`=1 with `par_o`=16'hFFFF, for either bus width.
- R11: A clear strobe in the middle of a page discards every earlier strobe. The resulting code depends only on the data strobed after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Page-start strobe: clears accumulators, counters and results |
| mode | input | 2 | Page size select, data bytes = 512 << mode |
| wide | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| strb | input | 1 | Data strobe, one bus word per cycle it is high |
| din | input | 16 | Bus data |
| par_o | output | 16 | Code bytes 0/1 before done; error position (syndrome) at done |
| npar_o | output | 16 | Code bytes 2/3 before done; inverse syndrome at done |
| code_rdy | output | 1 | Data phase complete, code valid, code bytes expected |
| err_any | output | 1 | Any mismatch found |
| err_multi | output | 1 | Uncorrectable (multiple) error |
| err_code | output | 1 | Single error inside the code bytes |
| done | output | 1 | Classification finished and held |

## Verification
A wrong word count would move `code_rdy` off the exact strobe that the page size and bus width call for. It would also skew the parity at the boundary, so it shows up on the first page. A misplaced bit index or word index in the accumulators would show up in the stored code at the end of the data phase. It would also show up in the reported position of a single injected error. A syndrome that is misclassified, captured in the wrong byte order, or latched one cycle off shows up within two cycles of the last code strobe. It would be seen as wrong flags, a wrong position, or a `done` edge in the wrong cycle.

// File: rtl/ecc_page_pkg.sv
package ecc_page_pkg;

    typedef enum logic [1:0] {
        ST_DATA  = 2'd0,
        ST_CODE  = 2'd1,
        ST_CHECK = 2'd2,
        ST_DONE  = 2'd3
    } ecc_state_t;

    typedef struct packed {
        logic any;
        logic multi;
        logic code;
    } ecc_flags_t;

endpackage

// File: rtl/ecc_par_accum.sv
module ecc_par_accum #(
    parameter int WADDR_W = 12,
    parameter int BOFF_W  = 4,
    localparam int BUS_W  = 1 << BOFF_W,
    localparam int BYTE_W = BUS_W / 2,
    localparam int POS_W  = WADDR_W + BOFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               en,
    input  logic               wide,
    input  logic [WADDR_W-1:0] widx,
    input  logic [BUS_W-1:0]   din,
    output logic [POS_W-1:0]   acc_p,
    output logic [POS_W-1:0]   acc_np
);

    logic [BUS_W-1:0]  dmask;
    logic [BOFF_W-1:0] lo_p;
    logic [BOFF_W-1:0] lo_np;
    logic              odd;
    logic [POS_W-1:0]  add_p;
    logic [POS_W-1:0]  add_np;

    // Narrow bus: the upper lane carries no page data
    assign dmask = wide ? din : {{BYTE_W{1'b0}}, din[BYTE_W-1:0]};

    always_comb begin
        lo_p  = '0;
        lo_np = '0;
        odd   = 1'b0;
        for (int b = 0; b < BUS_W; b++) begin
            if (dmask[b]) begin
                odd   = ~odd;
                lo_p  = lo_p ^ BOFF_W'(b);
                lo_np = lo_np ^ ~BOFF_W'(b);
            end
        end
    end

    // The word index counts once per set bit, so it survives only for an odd count
    assign add_p  = {{WADDR_W{odd}} & widx, lo_p};
    assign add_np = {{WADDR_W{odd}} & ~widx, lo_np};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_p  <= '0;
            acc_np <= '0;
        end else if (clr) begin
            acc_p  <= '0;
            acc_np <= '0;
        end else if (en) begin
            acc_p  <= acc_p ^ add_p;
            acc_np <= acc_np ^ add_np;
        end
    end

    // R2: no strobe, no change
    p_hold_no_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> ($stable(acc_p) && $stable(acc_np)));

endmodule

// File: rtl/ecc_syndrome.sv
module ecc_syndrome
    import ecc_page_pkg::*;
#(
    parameter int POS_W = 16
) (
    input  logic [POS_W-1:0] calc_p,
    input  logic [POS_W-1:0] calc_np,
    input  logic [POS_W-1:0] rx_p,
    input  logic [POS_W-1:0] rx_np,
    output logic [POS_W-1:0] syn_p,
    output logic [POS_W-1:0] syn_np,
    output ecc_flags_t       flags
);

    logic zero;
    logic single;
    logic one_hot;

    always_comb begin
        syn_p   = calc_p ^ rx_p;
        syn_np  = calc_np ^ rx_np;
        zero    = ~|{syn_p, syn_np};
        single  = &(syn_p ^ syn_np);
        one_hot = $onehot({syn_p, syn_np});
        flags.any   = !zero;
        flags.code  = one_hot;
        flags.multi = !zero && !single && !one_hot;
    end

endmodule

// File: rtl/ecc_page_engine.sv
module ecc_page_engine
    import ecc_page_pkg::*;
#(
    parameter int WADDR_W    = 12,
    parameter int BOFF_W     = 4,
    parameter int BASE_BYTES = 512,
    parameter int MODE_W     = 2,
    localparam int BUS_W     = 1 << BOFF_W,
    localparam int BYTE_W    = BUS_W / 2,
    localparam int POS_W     = WADDR_W + BOFF_W,
    localparam int CODE_W    = 2 * POS_W,
    localparam int LEN_W     = WADDR_W + 1,
    localparam int NUNIT_B   = CODE_W / BYTE_W,
    localparam int CC_W      = $clog2(NUNIT_B)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [MODE_W-1:0] mode,
    input  logic              wide,
    input  logic              strb,
    input  logic [BUS_W-1:0]  din,
    output logic [POS_W-1:0]  par_o,
    output logic [POS_W-1:0]  npar_o,
    output logic              code_rdy,
    output logic              err_any,
    output logic              err_multi,
    output logic              err_code,
    output logic              done
);

    ecc_state_t         state, nxt;
    logic [WADDR_W-1:0] wcnt;
    logic [CC_W-1:0]    ccnt;
    logic [CODE_W-1:0]  rx;
    logic [LEN_W-1:0]   len_bytes;
    logic [LEN_W-1:0]   len_words;
    logic               last_data;
    logic               last_code;
    logic [POS_W-1:0]   acc_p, acc_np;
    logic [POS_W-1:0]   syn_p, syn_np;
    logic [POS_W-1:0]   syn_p_q, syn_np_q;
    ecc_flags_t         flags, flags_q;

    assign len_bytes = LEN_W'(BASE_BYTES) << mode;
    assign len_words = wide ? (len_bytes >> 1) : len_bytes;
    assign last_data = ({1'b0, wcnt} == (len_words - LEN_W'(1)));
    assign last_code = wide ? (ccnt == CC_W'(NUNIT_B / 2 - 1))
                            : (ccnt == CC_W'(NUNIT_B - 1));

    ecc_par_accum #(.WADDR_W(WADDR_W), .BOFF_W(BOFF_W)) u_accum (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .en     (strb && (state == ST_DATA)),
        .wide   (wide),
        .widx   (wcnt),
        .din    (din),
        .acc_p  (acc_p),
        .acc_np (acc_np)
    );

    ecc_syndrome #(.POS_W(POS_W)) u_syn (
        .calc_p  (acc_p),
        .calc_np (acc_np),
        .rx_p    (rx[POS_W-1:0]),
        .rx_np   (rx[CODE_W-1:POS_W]),
        .syn_p   (syn_p),
        .syn_np  (syn_np),
        .flags   (flags)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state <= ST_DATA;
        else if (clr) state <= ST_DATA;
        else          state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_DATA:  if (strb && last_data) nxt = ST_CODE;
            ST_CODE:  if (strb && last_code) nxt = ST_CHECK;
            ST_CHECK: nxt = ST_DONE;
            ST_DONE:  nxt = ST_DONE;
        endcase
    end

    // Counters, code capture and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt     <= '0;
            ccnt     <= '0;
            rx       <= '0;
            flags_q  <= '0;
            syn_p_q  <= '0;
            syn_np_q <= '0;
        end else if (clr) begin
            wcnt     <= '0;
            ccnt     <= '0;
            rx       <= '0;
            flags_q  <= '0;
            syn_p_q  <= '0;
            syn_np_q <= '0;
        end else begin
            unique case (state)
                ST_DATA: if (strb) wcnt <= wcnt + WADDR_W'(1);
                ST_CODE: if (strb) begin
                    rx   <= wide ? {din, rx[CODE_W-1:BUS_W]}
                                 : {din[BYTE_W-1:0], rx[CODE_W-1:BYTE_W]};
                    ccnt <= ccnt + CC_W'(1);
                end
                ST_CHECK: begin
                    flags_q  <= flags;
                    syn_p_q  <= syn_p;
                    syn_np_q <= syn_np;
                end
                ST_DONE: ;
            endcase
        end
    end

    assign done      = (state == ST_DONE);
    assign code_rdy  = (state == ST_CODE);
    assign par_o     = done ? syn_p_q : acc_p;
    assign npar_o    = done ? syn_np_q : acc_np;
    assign err_any   = flags_q.any;
    assign err_multi = flags_q.multi;
    assign err_code  = flags_q.code;

    // R1: a clear leaves a blank engine
    p_clear_blank_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (par_o == '0 && npar_o == '0 && !done && !err_any && !code_rdy));

    // R5: the result holds until the next clear
    p_done_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr) |=> (done && $stable(par_o) && $stable(err_any) && $stable(err_multi)));

    // R9: an uncorrectable error is a mismatch and not a code error
    p_multi_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_multi |-> (err_any && !err_code));

    // R8: a code error is a mismatch
    p_code_any_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_code |-> err_any);

endmodule

// File: tb/test_ecc_page_engine.sv
module test_ecc_page_engine;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        wide = 1'b0;
    logic        strb = 1'b0;
    logic [15:0] din = 16'h0;
    logic [15:0] par_o, npar_o;
    logic        code_rdy, err_any, err_multi, err_code, done;

    int checks = 0;
    int errors = 0;
    logic [15:0] pg [0:4095];

    always #(CLK_PERIOD / 2) clk = ~clk;

    ecc_page_engine i_ecc_page_engine (
        .clk(clk), .rst_n(rst_n), .clr(clr), .mode(mode), .wide(wide),
        .strb(strb), .din(din), .par_o(par_o), .npar_o(npar_o),
        .code_rdy(code_rdy), .err_any(err_any), .err_multi(err_multi),
        .err_code(err_code), .done(done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int words_of(input logic [1:0] m, input bit w16);
        return (512 << m) >> (w16 ? 1 : 0);
    endfunction

    // Expected code {npar, par} from the position rule of R2
    function automatic logic [31:0] model_code(input int nw, input bit w16);
        logic [15:0] p = 16'h0;
        logic [15:0] np = 16'h0;
        for (int w = 0; w < nw; w++) begin
            logic [15:0] d = w16 ? pg[w] : {8'h00, pg[w][7:0]};
            for (int b = 0; b < 16; b++) begin
                if (d[b]) begin
                    p  = p ^ {w[11:0], b[3:0]};
                    np = np ^ ~{w[11:0], b[3:0]};
                end
            end
        end
        return {np, p};
    endfunction

    task automatic pulse_clr();
        @(negedge clk);
        strb = 1'b0;
        clr  = 1'b1;
        @(negedge clk);
        clr  = 1'b0;
    endtask

    task automatic send(input logic [15:0] d);
        @(negedge clk);
        strb = 1'b1;
        din  = d;
    endtask

    task automatic idle();
        @(negedge clk);
        strb = 1'b0;
        din  = 16'h0;
    endtask

    task automatic run_data(input string req, input logic [1:0] m, input bit w16);
        int nw = words_of(m, w16);
        logic [31:0] exp;
        mode = m;
        wide = w16;
        for (int i = 0; i < nw; i++) begin
            if (i == nw - 1) begin
                @(negedge clk);
                chk("R3 code_rdy before last word", {31'h0, code_rdy}, 32'h0);
                strb = 1'b1;
                din  = pg[i];
            end else begin
                send(pg[i]);
            end
        end
        idle();
        exp = model_code(nw, w16);
        chk({req, " code_rdy after last word"}, {31'h0, code_rdy}, 32'h1);
        chk({req, " stored code"}, {npar_o, par_o}, exp);
    endtask

    task automatic run_code(input logic [31:0] code, input bit w16);
        if (w16) begin
            send(code[15:0]);
            send(code[31:16]);
        end else begin
            for (int k = 0; k < 4; k++) send({$urandom_range(255, 0) % 256, code[8*k +: 8]});
        end
        idle();
        chk("R5 done low one cycle after last code", {31'h0, done}, 32'h0);
        @(negedge clk);
        chk("R5 done high two cycles after last code", {31'h0, done}, 32'h1);
    endtask

    task automatic fill_rand(input int nw);
        for (int i = 0; i < nw; i++) pg[i] = $urandom_range(65535, 0) % 65536;
    endtask

    task automatic chk_flags(input string req, input logic a, input logic m, input logic c);
        chk(req, {29'h0, err_any, err_multi, err_code}, {29'h0, a, m, c});
    endtask

    initial begin
        int unused_seed;
        logic [31:0] good;
        logic [15:0] hold;
        int nw, w1, w2, b1;
        unused_seed = $urandom(32'h5EED_0A11);

        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {par_o, npar_o}, 32'h0);
        chk_flags("R1 reset flags", 1'b0, 1'b0, 1'b0);
        chk("R1 reset done/code_rdy", {30'h0, done, code_rdy}, 32'h0);
        rst_n = 1'b1;

        // 8-bit, 512 bytes, junk upper lane (R2), clean read (R6)
        nw = words_of(2'd0, 1'b0);
        fill_rand(nw);
        pulse_clr();
        run_data("R2 R4 8-bit mode0", 2'd0, 1'b0);
        good = {npar_o, par_o};
        pulse_clr();
        run_data("R3 8-bit reread", 2'd0, 1'b0);
        run_code(good, 1'b0);
        chk_flags("R6 clean page flags", 1'b0, 1'b0, 1'b0);
        chk("R6 clean page position", {16'h0, par_o}, 32'h0);

        // R5: strobes after done are ignored
        hold = par_o;
        send(16'hA5A5);
        send(16'h5A5A);
        idle();
        chk("R5 done holds", {31'h0, done}, 32'h1);
        chk("R5 par_o stable", {16'h0, par_o}, {16'h0, hold});

        // R1 clear after done
        pulse_clr();
        chk("R1 clear outputs", {par_o, npar_o}, 32'h0);
        chk("R1 clear done", {31'h0, done}, 32'h0);

        // 16-bit, 1024 bytes, single data error (R7)
        nw = words_of(2'd1, 1'b1);
        fill_rand(nw);
        run_data("R4 16-bit mode1", 2'd1, 1'b1);
        good = {npar_o, par_o};
        w1 = $urandom_range(nw - 1, 0);
        b1 = $urandom_range(15, 0);
        pg[w1][b1] = ~pg[w1][b1];
        pulse_clr();
        mode = 2'd1; wide = 1'b1;
        for (int i = 0; i < nw; i++) send(pg[i]);
        idle();
        run_code(good, 1'b1);
        chk_flags("R7 16-bit single data error flags", 1'b1, 1'b0, 1'b0);
        chk("R7 16-bit position", {16'h0, par_o}, {16'h0, w1[11:0], b1[3:0]});

        // 8-bit single data error (R7)
        nw = words_of(2'd0, 1'b0);
        fill_rand(nw);
        pulse_clr();
        run_data("R2 8-bit second page", 2'd0, 1'b0);
        good = {npar_o, par_o};
        w1 = $urandom_range(nw - 1, 0);
        b1 = $urandom_range(7, 0);
        pg[w1][b1] = ~pg[w1][b1];
        pulse_clr();
        for (int i = 0; i < nw; i++) send(pg[i]);
        idle();
        run_code(good, 1'b0);
        chk_flags("R7 8-bit single data error flags", 1'b1, 1'b0, 1'b0);
        chk("R7 8-bit position", {16'h0, par_o}, {16'h0, w1[11:0], 1'b0, b1[2:0]});

        // Code error (R8): restore data, flip one code bit
        pg[w1][b1] = ~pg[w1][b1];
        b1 = $urandom_range(31, 0);
        good[b1] = ~good[b1];
        pulse_clr();
        for (int i = 0; i < nw; i++) send(pg[i]);
        idle();
        run_code(good, 1'b0);
        chk_flags("R8 code-bit error flags", 1'b1, 1'b0, 1'b1);
        good[b1] = ~good[b1];

        // Two data errors (R9)
        w1 = $urandom_range(nw / 2 - 1, 0);
        w2 = w1 + nw / 2;
        pg[w1][3] = ~pg[w1][3];
        pg[w2][6] = ~pg[w2][6];
        pulse_clr();
        for (int i = 0; i < nw; i++) send(pg[i]);
        idle();
        run_code(good, 1'b0);
        chk_flags("R9 double error flags", 1'b1, 1'b1, 1'b0);

        // Erased pages (R10), upper lane driven high on the 8-bit bus
        for (int i = 0; i < 4096; i++) pg[i] = 16'hFFFF;
        pulse_clr();
        mode = 2'd0; wide = 1'b0;
        for (int i = 0; i < 512; i++) send(pg[i]);
        idle();
        run_code(32'hFFFF_FFFF, 1'b0);
        chk_flags("R10 erased 8-bit flags", 1'b1, 1'b1, 1'b0);
        chk("R10 erased 8-bit position", {16'h0, par_o}, 32'h0000_FFFF);
        pulse_clr();
        mode = 2'd2; wide = 1'b1;
        for (int i = 0; i < 1024; i++) send(pg[i]);
        idle();
        run_code(32'hFFFF_FFFF, 1'b1);
        chk_flags("R10 erased 16-bit flags", 1'b1, 1'b1, 1'b0);
        chk("R10 erased 16-bit position", {16'h0, par_o}, 32'h0000_FFFF);

        // R11: junk cycles before a clear are discarded
        nw = words_of(2'd0, 1'b1);
        fill_rand(nw);
        pulse_clr();
        mode = 2'd0; wide = 1'b1;
        for (int i = 0; i < 5; i++) send(16'h1234 + 16'(i));
        idle();
        pulse_clr();
        run_data("R11 clear discards earlier cycles", 2'd0, 1'b1);

        // Largest page, 8-bit (R3), clean read
        nw = words_of(2'd3, 1'b0);
        fill_rand(nw);
        pulse_clr();
        run_data("R3 8-bit mode3", 2'd3, 1'b0);
        good = {npar_o, par_o};
        run_code(good, 1'b0);
        chk_flags("R6 mode3 own code flags", 1'b0, 1'b0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule